// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a byte-wide host bus slave that presents a legacy configuration space through two adjacent bus addresses: an index port and a data port one address above it. The host first writes the number of the register it wants into the index port. It then reads or writes that register through the data port. A pair of strap inputs chooses the index port address and the identification byte that the block reports.

The space holds three global registers: an identification byte, a global configuration byte whose bit 0 enables the chip, and a unit select. The unit select banks the unit-specific registers. Only the general-purpose I/O unit (unit number 7) is implemented. It has an activate byte, a 16-bit runtime base address split across two registers, and a pin select. The pin select points the pin configuration and pin event registers at one of the per-pin storage bytes.

The base address, the effective activate flag and every pin's configuration and event bytes are driven out continuously. The runtime I/O logic that sits beside this block uses them.

Top module: `cfg_idx_port`

## Requirements
- R1: With `addr_strap` low the index port is at 0x002E, and with it high at 0x004E. The data port is at the index port address plus one. A write to any other address changes no state, and a read of any other address returns 0x00.
- R2: Read data appears on `rdata` in the cycle after `rd` is high and is 0x00 in any cycle not preceded by `rd`. Reading the index port returns the index last written.
- R3: Data index 0x20 reads the identification byte: 0xE9 with `id_strap` low, 0xE5 with it high. Writes to index 0x20 are ignored.
- R4: Data index 0x21 is a read/write global configuration byte that resets to 0x01. Its bit 0 is the chip enable.
- R5: Data index 0x07 is a read/write unit select that resets to 0x00. The unit-specific indices 0x30, 0x60, 0x61 and 0xF0 to 0xF2 reach the I/O unit only while it holds 7.
- R6: Index 0x30 is the I/O unit's activate byte, reset 0x01. `gpio_active` is high exactly when the activate byte is nonzero and chip enable bit 0 of index 0x21 is 1.
- R7: Indices 0x60 and 0x61 hold the high and low bytes of `gpio_base`, which resets to the parameter RESET_BASE (0x0680 by default).
- R8: Index 0xF0 is the pin select. Bits [6:4] give the port and bits [2:0] the bit, so pin n = port*8 + bit. The other bits read back as 0. Ports at or above NUM_PINS/8 select no pin.
- R9: Indices 0xF1 and 0xF2 read and write the configuration byte and the event byte of the selected pin. Each pin keeps its own bytes, reset to 0x00. Pin n's bytes appear on `pin_cfg[8n+7:8n]` and `pin_evt[8n+7:8n]`. With no pin selected, these indices read 0x00 and ignore writes.
- R10: While the unit select is not 7, the unit-specific indices read 0x00 and writes to them change nothing.
- R11: Any index not listed above reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Index port address strap (0: 0x2E, 1: 0x4E) |
| id_strap | input | 1 | Identification byte strap (0: 0xE9, 1: 0xE5) |
| addr | input | 16 | Host bus address |
| wdata | input | 8 | Host write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid the cycle after rd |
| gpio_base | output | 16 | I/O unit runtime base address |
| gpio_active | output | 1 | I/O unit enabled and chip enabled |
| pin_cfg | output | 8*NUM_PINS | Per-pin configuration bytes |
| pin_evt | output | 8*NUM_PINS | Per-pin event bytes |

## Verification
The bound checker watches every cycle for these conditions: idle read data staying at zero, the identification byte returned to reads of index 0x20, stray-address writes and writes under a foreign unit leaving the exported state untouched, the exports holding still without writes, and a zero activate write dropping `gpio_active`. Some behaviour shows only in the bench's scenarios: the packed pin-select decode, each pin keeping its own bytes, reset values, the strap-chosen address and identification after a reset, and the read-back of every register. There, random index/data traffic is compared with a reference model of the register space.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam logic [7:0] IX_UNIT  = 8'h07;
    localparam logic [7:0] IX_ID    = 8'h20;
    localparam logic [7:0] IX_GCFG  = 8'h21;
    localparam logic [7:0] IX_ACT   = 8'h30;
    localparam logic [7:0] IX_BHI   = 8'h60;
    localparam logic [7:0] IX_BLO   = 8'h61;
    localparam logic [7:0] IX_PSEL  = 8'hF0;
    localparam logic [7:0] IX_PCFG  = 8'hF1;
    localparam logic [7:0] IX_PEVT  = 8'hF2;

    localparam logic [7:0] PSEL_MASK = 8'h77;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] unit;
        logic [7:0] gcfg;
        logic [7:0] act;
        logic [7:0] base_hi;
        logic [7:0] base_lo;
        logic [7:0] psel;
        logic [7:0] rdata;
    } cfgp_state_t;

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
    parameter logic [15:0] IDX_ADDR_A = 16'h002E,
    parameter logic [15:0] IDX_ADDR_B = 16'h004E
) (
    input  logic        addr_strap,
    input  logic [15:0] addr,
    output logic        hit_idx,
    output logic        hit_dat
);
    logic [15:0] idx_addr;

    always_comb begin
        idx_addr = addr_strap ? IDX_ADDR_B : IDX_ADDR_A;
        hit_idx  = (addr == idx_addr);
        hit_dat  = (addr == idx_addr + 16'd1);
    end
endmodule

// File: rtl/cfgp_pin_store.sv
module cfgp_pin_store #(
    parameter int NUM_PINS = 32,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIN_W-1:0]      pin,
    input  logic                  we_cfg,
    input  logic                  we_evt,
    input  logic [7:0]            wdata,
    output logic [7:0]            rd_cfg,
    output logic [7:0]            rd_evt,
    output logic [NUM_PINS*8-1:0] cfg_flat,
    output logic [NUM_PINS*8-1:0] evt_flat
);
    logic [NUM_PINS-1:0][7:0] cfg_d, cfg_q;
    logic [NUM_PINS-1:0][7:0] evt_d, evt_q;

    always_comb begin
        cfg_d = cfg_q;
        evt_d = evt_q;
        if (we_cfg) cfg_d[pin] = wdata;
        if (we_evt) evt_d[pin] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            evt_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            evt_q <= evt_d;
        end
    end

    assign rd_cfg = cfg_q[pin];
    assign rd_evt = evt_q[pin];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_flat
        assign cfg_flat[g*8 +: 8] = cfg_q[g];
        assign evt_flat[g*8 +: 8] = evt_q[g];
    end
endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
    import cfgp_pkg::*;
#(
    parameter logic [15:0] IDX_ADDR_A = 16'h002E,
    parameter logic [15:0] IDX_ADDR_B = 16'h004E,
    parameter logic [7:0]  ID_PRI     = 8'hE9,
    parameter logic [7:0]  ID_ALT     = 8'hE5,
    parameter logic [7:0]  GPIO_UNIT  = 8'h07,
    parameter logic [15:0] RESET_BASE = 16'h0680,
    parameter int          NUM_PINS   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_strap,
    input  logic                  id_strap,
    input  logic [15:0]           addr,
    input  logic [7:0]            wdata,
    input  logic                  wr,
    input  logic                  rd,
    output logic [7:0]            rdata,
    output logic [15:0]           gpio_base,
    output logic                  gpio_active,
    output logic [NUM_PINS*8-1:0] pin_cfg,
    output logic [NUM_PINS*8-1:0] pin_evt
);
    localparam int PORTS  = NUM_PINS / 8;
    localparam int PORT_W = $clog2(PORTS);
    localparam int PIN_W  = $clog2(NUM_PINS);

    cfgp_state_t q, d;

    logic             hit_idx, hit_dat;
    logic             unit_is_gpio;
    logic             pin_ok;
    logic [PIN_W-1:0] pin_sel;
    logic             we_cfg, we_evt;
    logic [7:0]       pin_rd_cfg, pin_rd_evt;
    logic [7:0]       reg_val;
    logic [7:0]       cur_index, cur_unit;

    cfgp_decode #(
        .IDX_ADDR_A (IDX_ADDR_A),
        .IDX_ADDR_B (IDX_ADDR_B)
    ) u_dec (
        .addr_strap (addr_strap),
        .addr       (addr),
        .hit_idx    (hit_idx),
        .hit_dat    (hit_dat)
    );

    // Packed pin select: port in [6:4], bit in [2:0]
    always_comb begin
        unit_is_gpio = (q.unit == GPIO_UNIT);
        pin_ok       = (int'(q.psel[6:4]) < PORTS);
        pin_sel      = {q.psel[4 +: PORT_W], q.psel[2:0]};
    end

    cfgp_pin_store #(
        .NUM_PINS (NUM_PINS)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pin_sel),
        .we_cfg   (we_cfg),
        .we_evt   (we_evt),
        .wdata    (wdata),
        .rd_cfg   (pin_rd_cfg),
        .rd_evt   (pin_rd_evt),
        .cfg_flat (pin_cfg),
        .evt_flat (pin_evt)
    );

    // Value seen through the data port for the current index
    always_comb begin
        reg_val = 8'h00;
        case (q.index)
            IX_UNIT: reg_val = q.unit;
            IX_ID:   reg_val = id_strap ? ID_ALT : ID_PRI;
            IX_GCFG: reg_val = q.gcfg;
            IX_ACT:  if (unit_is_gpio) reg_val = q.act;
            IX_BHI:  if (unit_is_gpio) reg_val = q.base_hi;
            IX_BLO:  if (unit_is_gpio) reg_val = q.base_lo;
            IX_PSEL: if (unit_is_gpio) reg_val = q.psel;
            IX_PCFG: if (unit_is_gpio && pin_ok) reg_val = pin_rd_cfg;
            IX_PEVT: if (unit_is_gpio && pin_ok) reg_val = pin_rd_evt;
            default: reg_val = 8'h00;
        endcase
    end

    always_comb begin
        d      = q;
        we_cfg = 1'b0;
        we_evt = 1'b0;

        if (wr && hit_idx) begin
            d.index = wdata;
        end else if (wr && hit_dat) begin
            case (q.index)
                IX_UNIT: d.unit = wdata;
                IX_GCFG: d.gcfg = wdata;
                IX_ACT:  if (unit_is_gpio) d.act     = wdata;
                IX_BHI:  if (unit_is_gpio) d.base_hi = wdata;
                IX_BLO:  if (unit_is_gpio) d.base_lo = wdata;
                IX_PSEL: if (unit_is_gpio) d.psel    = wdata & PSEL_MASK;
                IX_PCFG: we_cfg = unit_is_gpio && pin_ok;
                IX_PEVT: we_evt = unit_is_gpio && pin_ok;
                default: ;
            endcase
        end

        if (rd && hit_idx)      d.rdata = q.index;
        else if (rd && hit_dat) d.rdata = reg_val;
        else                    d.rdata = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.index   <= 8'h00;
            q.unit    <= 8'h00;
            q.gcfg    <= 8'h01;
            q.act     <= 8'h01;
            q.base_hi <= RESET_BASE[15:8];
            q.base_lo <= RESET_BASE[7:0];
            q.psel    <= 8'h00;
            q.rdata   <= 8'h00;
        end else begin
            q <= d;
        end
    end

    assign rdata       = q.rdata;
    assign gpio_base   = {q.base_hi, q.base_lo};
    assign gpio_active = q.gcfg[0] && (q.act != 8'h00);
    assign cur_index   = q.index;
    assign cur_unit    = q.unit;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter logic [7:0] ID_PRI    = 8'hE9,
    parameter logic [7:0] ID_ALT    = 8'hE5,
    parameter logic [7:0] GPIO_UNIT = 8'h07,
    parameter int         NUM_PINS  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  id_strap,
    input logic                  wr,
    input logic                  rd,
    input logic [7:0]            wdata,
    input logic                  hit_idx,
    input logic                  hit_dat,
    input logic [7:0]            cur_index,
    input logic [7:0]            cur_unit,
    input logic [7:0]            rdata,
    input logic [15:0]           gpio_base,
    input logic                  gpio_active,
    input logic [NUM_PINS*8-1:0] pin_cfg,
    input logic [NUM_PINS*8-1:0] pin_evt
);
    assert_stray_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit_idx && !hit_dat) |=>
        ($stable(cur_index) && $stable(cur_unit) && $stable(gpio_base) &&
         $stable(gpio_active) && $stable(pin_cfg) && $stable(pin_evt)));

    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == 8'h00));

    assert_chip_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_dat && cur_index == 8'h20) |=>
        (rdata == (id_strap ? ID_ALT : ID_PRI)));

    assert_deactivate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_dat && cur_unit == GPIO_UNIT && cur_index == 8'h30 &&
         wdata == 8'h00) |=> !gpio_active);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(gpio_base) && $stable(gpio_active) &&
                 $stable(pin_cfg) && $stable(pin_evt)));

    assert_foreign_unit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_dat && cur_unit != GPIO_UNIT &&
         cur_index != 8'h07 && cur_index != 8'h21) |=>
        ($stable(gpio_base) && $stable(gpio_active) &&
         $stable(pin_cfg) && $stable(pin_evt)));
endmodule

bind cfg_idx_port cfgp_checker #(
    .ID_PRI    (ID_PRI),
    .ID_ALT    (ID_ALT),
    .GPIO_UNIT (GPIO_UNIT),
    .NUM_PINS  (NUM_PINS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_strap    (id_strap),
    .wr          (wr),
    .rd          (rd),
    .wdata       (wdata),
    .hit_idx     (hit_idx),
    .hit_dat     (hit_dat),
    .cur_index   (cur_index),
    .cur_unit    (cur_unit),
    .rdata       (rdata),
    .gpio_base   (gpio_base),
    .gpio_active (gpio_active),
    .pin_cfg     (pin_cfg),
    .pin_evt     (pin_evt)
);

// File: tb/sim_cfg_idx_port.sv
module sim_cfg_idx_port;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_strap = 1'b0;
    logic          id_strap = 1'b0;
    logic [15:0]   addr = 16'h0000;
    logic [7:0]    wdata = 8'h00;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    rdata;
    logic [15:0]   gpio_base;
    logic          gpio_active;
    logic [NP*8-1:0] pin_cfg;
    logic [NP*8-1:0] pin_evt;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [7:0] m_idx, m_unit, m_gcfg, m_act, m_bhi, m_blo, m_sel;
    logic [7:0] m_pcfg [NP];
    logic [7:0] m_pevt [NP];

    cfg_idx_port #(.NUM_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .id_strap(id_strap),
        .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata),
        .gpio_base(gpio_base), .gpio_active(gpio_active),
        .pin_cfg(pin_cfg), .pin_evt(pin_evt)
    );

    always #2.5 clk = ~clk;

    initial begin
        #900000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [15:0] ia();
        return addr_strap ? 16'h004E : 16'h002E;
    endfunction

    function automatic bit m_pin_ok();
        return m_sel[6:4] < 3'd4;
    endfunction

    function automatic int m_pin();
        return int'(m_sel[5:4]) * 8 + int'(m_sel[2:0]);
    endfunction

    function automatic logic [7:0] m_read();
        bit g = (m_unit == 8'h07);
        case (m_idx)
            8'h07: return m_unit;
            8'h20: return id_strap ? 8'hE5 : 8'hE9;
            8'h21: return m_gcfg;
            8'h30: return g ? m_act : 8'h00;
            8'h60: return g ? m_bhi : 8'h00;
            8'h61: return g ? m_blo : 8'h00;
            8'hF0: return g ? m_sel : 8'h00;
            8'hF1: return (g && m_pin_ok()) ? m_pcfg[m_pin()] : 8'h00;
            8'hF2: return (g && m_pin_ok()) ? m_pevt[m_pin()] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        m_idx = 0; m_unit = 0; m_gcfg = 8'h01; m_act = 8'h01;
        m_bhi = 8'h06; m_blo = 8'h80; m_sel = 0;
        for (int i = 0; i < NP; i++) begin
            m_pcfg[i] = 0;
            m_pevt[i] = 0;
        end
    endtask

    task automatic m_write(input logic [15:0] a, input logic [7:0] v);
        bit g = (m_unit == 8'h07);
        if (a == ia()) m_idx = v;
        else if (a == ia() + 16'd1) begin
            case (m_idx)
                8'h07: m_unit = v;
                8'h21: m_gcfg = v;
                8'h30: if (g) m_act = v;
                8'h60: if (g) m_bhi = v;
                8'h61: if (g) m_blo = v;
                8'hF0: if (g) m_sel = v & 8'h77;
                8'hF1: if (g && m_pin_ok()) m_pcfg[m_pin()] = v;
                8'hF2: if (g && m_pin_ok()) m_pevt[m_pin()] = v;
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        m_write(a, v);
    endtask

    task automatic bus_rd(input logic [15:0] a, input string req);
        logic [7:0] exp;
        if (a == ia()) exp = m_idx;
        else if (a == ia() + 16'd1) exp = m_read();
        else exp = 8'h00;
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk(req, {24'h0, rdata}, {24'h0, exp});
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
        bus_wr(ia(), ix);
        bus_wr(ia() + 16'd1, v);
    endtask

    task automatic reg_rd(input logic [7:0] ix, input string req);
        bus_wr(ia(), ix);
        bus_rd(ia() + 16'd1, req);
    endtask

    task automatic chk_exports(input string req);
        chk({req, " base"}, {16'h0, gpio_base}, {16'h0, m_bhi, m_blo});
        chk({req, " active"}, {31'h0, gpio_active},
            {31'h0, (m_gcfg[0] && m_act != 8'h00)});
        for (int i = 0; i < NP; i++) begin
            chk({req, " pin_cfg"}, {24'h0, pin_cfg[i*8 +: 8]}, {24'h0, m_pcfg[i]});
            chk({req, " pin_evt"}, {24'h0, pin_evt[i*8 +: 8]}, {24'h0, m_pevt[i]});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        @(negedge clk);
    endtask

    function automatic logic [7:0] pick_index(input int r);
        case (r % 11)
            0: return 8'h07;  1: return 8'h20;  2: return 8'h21;
            3: return 8'h30;  4: return 8'h60;  5: return 8'h61;
            6: return 8'hF0;  7: return 8'hF1;  8: return 8'hF2;
            9: return 8'hF1;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // reset state
        chk("R2 reset rdata", {24'h0, rdata}, 32'h0);
        chk_exports("R7 R9 reset");
        reg_rd(8'h21, "R4 gcfg reset");
        reg_rd(8'h07, "R5 unit reset");
        reg_rd(8'h20, "R3 id primary");
        reg_wr(8'h20, 8'h12);
        reg_rd(8'h20, "R3 id write ignored");

        // index readback, stray addresses
        bus_wr(ia(), 8'h5A);
        bus_rd(ia(), "R2 index readback");
        bus_wr(16'h004E, 8'h33);
        bus_wr(16'h004F, 8'h44);
        bus_rd(ia(), "R1 stray write ignored");
        bus_rd(16'h004F, "R1 stray read zero");
        chk_exports("R1 stray exports");

        // I/O unit registers
        reg_wr(8'h07, 8'h07);
        reg_rd(8'h30, "R6 act reset");
        reg_rd(8'h60, "R7 base hi reset");
        reg_rd(8'h61, "R7 base lo reset");
        reg_wr(8'h60, 8'hA5);
        reg_wr(8'h61, 8'h3C);
        chk_exports("R7 base written");
        reg_wr(8'h30, 8'h00);
        chk_exports("R6 deactivate");
        reg_wr(8'h30, 8'h80);
        reg_wr(8'h21, 8'hFE);
        chk_exports("R6 R4 chip enable low");
        reg_wr(8'h21, 8'h01);
        chk_exports("R6 reactivate");

        // pin select encoding corners: pins 0, 7, 8, 31
        reg_wr(8'hF0, 8'hFF);
        reg_rd(8'hF0, "R8 psel mask");
        for (int k = 0; k < 4; k++) begin
            int p = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 8 : 31;
            reg_wr(8'hF0, 8'(((p << 1) & 8'hF0) | (p & 7)));
            reg_wr(8'hF1, 8'(8'h10 + p));
            reg_wr(8'hF2, 8'(8'h80 + p));
        end
        chk_exports("R8 R9 pin corners");
        reg_wr(8'hF0, 8'h47);
        reg_rd(8'hF1, "R9 no pin reads zero");
        reg_wr(8'hF1, 8'hEE);
        chk_exports("R9 no pin write ignored");

        // foreign unit
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h60, "R10 foreign base reads zero");
        reg_wr(8'h61, 8'h99);
        reg_wr(8'h30, 8'h00);
        chk_exports("R10 foreign writes ignored");
        reg_wr(8'h07, 8'h07);

        // unimplemented index
        reg_wr(8'h44, 8'h77);
        reg_rd(8'h44, "R11 unimplemented");
        chk_exports("R11 no effect");

        // constrained random traffic
        for (int it = 0; it < 3000; it++) begin
            int r = int'($urandom % 16);
            if (r < 5) reg_wr(pick_index(int'($urandom)),
                              8'((($urandom % 4) == 0) ? 8'h07 : $urandom));
            else if (r < 9) reg_rd(pick_index(int'($urandom)), "R9 random read");
            else if (r < 11) reg_wr(8'hF0, 8'($urandom));
            else if (r < 12) bus_rd(ia(), "R2 random index read");
            else if (r < 13) bus_wr(16'($urandom), 8'($urandom));
            else if (r < 14) reg_wr(8'h07, 8'h07);
            else reg_wr(8'hF1, 8'($urandom));
            if (it % 500 == 0) chk_exports("R9 random exports");
        end
        chk_exports("R9 final exports");

        // alternate straps
        addr_strap = 1'b1;
        id_strap = 1'b1;
        do_reset();
        reg_rd(8'h20, "R3 id alternate");
        bus_wr(16'h002E, 8'h21);
        bus_rd(16'h004E, "R1 old index port ignored");
        reg_wr(8'h07, 8'h07);
        reg_wr(8'h60, 8'h12);
        chk_exports("R1 alternate address");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule